// File: doc/BRIEF.md
# Byte-Strobe Burst Write Controller for Asynchronous Static RAM

This block turns a stream of word write requests into the control waveforms of an asynchronous 16-bit static RAM. The RAM has active-low chip select, write strobe, output enable and one active-low strobe for each byte lane. Requests arrive on a valid/ready handshake. Each request carries an address, a 16-bit word and a 2-bit lane mask. All intervals are counted in cycles of the system clock.

The write strobe falls once and stays low for as long as requests keep arriving back to back. Inside that window the controller marks each word by pulsing the byte-lane strobes. The lane strobes therefore set the edges that address and data setup and hold are measured against. The memory's output enable stays high at all times, so the RAM never drives the shared data pins. The controller turns on its own data driver only after the write strobe has been low for a turn-off interval.

Each word takes a setup phase of `T_AS` cycles, a strobe pulse of `T_PW` cycles and a hold phase of `HOLD = max(T_AH, T_WC - T_AS - T_PW)` cycles. A burst begins with a turn-off phase of `T_TURN` cycles and ends with one closing cycle.

Top module: `sbw_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, chip select, write strobe, output enable and both lane strobes are high, the data driver enable is low and ready is high.
- R2: A lane strobe is low only while chip select and the write strobe are low and the data driver is on. Output enable is high at every cycle.
- R3: Mask bit 0 drives the lower-lane strobe (data bits 7:0) and mask bit 1 drives the upper-lane strobe (data bits 15:8). A request with mask 0 is consumed, and no strobe goes low for it.
- R4: Every lane strobe pulse lasts exactly `T_PW` cycles, and address and data do not change while it lasts.
- R5: Address and data are stable for at least `T_AS` cycles before a lane strobe falls.
- R6: Requests accepted back to back keep the write strobe low throughout, so a burst has exactly one falling edge of the write strobe.
- R7: Inside one write-strobe-low window, successive strobe falls are a whole multiple of `T_AS + T_PW + HOLD` cycles apart. That distance is at least `T_WC`.
- R8: The data driver enable rises exactly `T_TURN` cycles after the write strobe falls.
- R9: When no request is waiting, the write strobe rises `HOLD` cycles after the last lane strobe rises. The data driver turns off at that same edge, and chip select rises one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request taken at this clock edge if valid |
| req_addr | input | AW | Word address |
| req_data | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 lower lane, bit 1 upper lane |
| mem_addr | output | AW | RAM address |
| mem_dq_out | output | 16 | Data toward the RAM pins |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low, held high |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |

## Verification
The embedded properties assume that reset is held for at least one clock edge. They also assume that req_addr, req_data and req_mask are stable whenever req_valid is high, and that the timing parameters are at least 1. The stimulus changes request fields only at falling clock edges. It holds each request until ready is seen, and it keeps the timing parameters at small legal values. Addresses are drawn from a 16-word window so that a bench memory model can confirm the final contents after random masks, repeated addresses and idle gaps that split bursts.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_OPEN,
      PH_SETUP,
      PH_PULSE,
      PH_HOLD,
      PH_CLOSE
   } phase_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/sbw_timer.sv
module sbw_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= CW'(1);
      else if (load)
         cnt <= load_val;
      else if (cnt > CW'(1))
         cnt <= cnt - CW'(1);
   end

   assign last = (cnt == CW'(1));

   // phase lengths rely on a strict one-per-cycle countdown (R4, R8)
   p_countdown_r4: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt > CW'(1)) |=> (cnt == $past(cnt) - CW'(1)));
   p_never_zero_r8: assert property (@(posedge clk) disable iff (rst)
      cnt != '0);
endmodule

// File: rtl/sbw_word_reg.sv
module sbw_word_reg #(
   parameter int AW = 17,
   parameter int DW = 16,
   parameter int NL = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_data,
   input  logic [NL-1:0] in_mask,
   output logic [AW-1:0] q_addr,
   output logic [DW-1:0] q_data,
   output logic [NL-1:0] q_mask
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_addr <= '0;
         q_data <= '0;
         q_mask <= '0;
      end else if (load) begin
         q_addr <= in_addr;
         q_data <= in_data;
         q_mask <= in_mask;
      end
   end
endmodule

// File: rtl/sbw_ctrl.sv
module sbw_ctrl
   import sbw_pkg::*;
#(
   parameter int AW     = 17,
   parameter int DW     = 16,
   parameter int T_AS   = 2,
   parameter int T_PW   = 3,
   parameter int T_AH   = 1,
   parameter int T_WC   = 8,
   parameter int T_TURN = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_data,
   input  logic [1:0]    req_mask,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_out,
   output logic          mem_dq_oe,
   output logic          mem_ce_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic          mem_ub_n,
   output logic          mem_lb_n
);
   localparam int NL     = DW / 8;
   localparam int HOLD   = imax(T_AH, T_WC - T_AS - T_PW);
   localparam int MAXLEN = imax(imax(T_AS, T_PW), imax(HOLD, T_TURN));
   localparam int CW     = $clog2(MAXLEN + 1) + 1;

   generate
      if (T_AS < 1 || T_PW < 1 || T_AH < 1 || T_WC < 1 || T_TURN < 1) begin : g_bad_timing
         $error("sbw_ctrl: every timing parameter must be at least 1");
      end
      if (DW != 16) begin : g_bad_width
         $error("sbw_ctrl: data width must be 16 (two byte lanes)");
      end
      if (AW < 1) begin : g_bad_addr
         $error("sbw_ctrl: address width must be positive");
      end
   endgenerate

   phase_e        ph, ph_nxt;
   logic          t_load, t_last, take;
   logic [CW-1:0] t_val;
   logic [NL-1:0] lane_mask;
   logic [NL-1:0] lane_n;

   sbw_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .last(t_last)
   );

   sbw_word_reg #(.AW(AW), .DW(DW), .NL(NL)) u_word (
      .clk(clk), .rst(rst), .load(take),
      .in_addr(req_addr), .in_data(req_data), .in_mask(req_mask),
      .q_addr(mem_addr), .q_data(mem_dq_out), .q_mask(lane_mask)
   );

   always_comb begin
      ph_nxt = ph;
      t_load = 1'b0;
      t_val  = CW'(1);
      take   = 1'b0;
      unique case (ph)
         PH_IDLE:
            if (req_valid) begin
               take = 1'b1; ph_nxt = PH_OPEN; t_load = 1'b1; t_val = CW'(T_TURN);
            end
         PH_OPEN:
            if (t_last) begin
               ph_nxt = PH_SETUP; t_load = 1'b1; t_val = CW'(T_AS);
            end
         PH_SETUP:
            if (t_last) begin
               ph_nxt = PH_PULSE; t_load = 1'b1; t_val = CW'(T_PW);
            end
         PH_PULSE:
            if (t_last) begin
               ph_nxt = PH_HOLD; t_load = 1'b1; t_val = CW'(HOLD);
            end
         PH_HOLD:
            if (t_last) begin
               t_load = 1'b1;
               if (req_valid) begin
                  take = 1'b1; ph_nxt = PH_SETUP; t_val = CW'(T_AS);
               end else begin
                  ph_nxt = PH_CLOSE;
               end
            end
         PH_CLOSE: ph_nxt = PH_IDLE;
         default:  ph_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) ph <= PH_IDLE;
      else     ph <= ph_nxt;
   end

   assign req_ready = (ph == PH_IDLE) || (ph == PH_HOLD && t_last);
   assign mem_ce_n  = (ph == PH_IDLE);
   assign mem_we_n  = (ph == PH_IDLE) || (ph == PH_CLOSE);
   assign mem_dq_oe = (ph == PH_SETUP) || (ph == PH_PULSE) || (ph == PH_HOLD);
   assign mem_oe_n  = 1'b1;

   generate
      for (genvar i = 0; i < NL; i++) begin : g_lane
         assign lane_n[i] = !((ph == PH_PULSE) && lane_mask[i]);
      end
   endgenerate

   assign mem_lb_n = lane_n[0];
   assign mem_ub_n = lane_n[1];

   p_strobe_qual_r2: assert property (@(posedge clk) disable iff (rst)
      (!mem_lb_n || !mem_ub_n) |-> (!mem_ce_n && !mem_we_n && mem_dq_oe));
   p_oe_high_r2: assert property (@(posedge clk) disable iff (rst)
      mem_oe_n);
   p_pulse_stable_r4: assert property (@(posedge clk) disable iff (rst)
      (ph == PH_PULSE && $past(ph) == PH_PULSE) |-> ($stable(mem_addr) && $stable(mem_dq_out)));
   p_turnoff_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_we_n) |-> !mem_dq_oe);
   p_no_drive_we_high_r8: assert property (@(posedge clk) disable iff (rst)
      mem_we_n |-> !mem_dq_oe);
   p_release_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(mem_dq_oe) |-> $rose(mem_we_n));
   p_ce_after_we_r9: assert property (@(posedge clk) disable iff (rst)
      $rose(mem_ce_n) |-> $past(mem_we_n));
   p_ce_covers_we_r6: assert property (@(posedge clk) disable iff (rst)
      mem_ce_n |-> mem_we_n);
endmodule

// File: tb/sbw_ctrl_test.sv
module sbw_ctrl_test;
   localparam int AW = 17, T_AS = 2, T_PW = 3, T_AH = 1, T_WC = 8, T_TURN = 2;
   localparam int HOLD = (T_AH > T_WC - T_AS - T_PW) ? T_AH : T_WC - T_AS - T_PW;
   localparam int WORD = T_AS + T_PW + HOLD;

   logic clk = 0, rst = 1;
   logic req_valid = 0, req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [15:0] req_data = '0;
   logic [1:0] req_mask = '0;
   logic [AW-1:0] mem_addr;
   logic [15:0] mem_dq_out;
   logic mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;

   sbw_ctrl #(.AW(AW), .T_AS(T_AS), .T_PW(T_PW), .T_AH(T_AH), .T_WC(T_WC), .T_TURN(T_TURN)) uut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .req_mask(req_mask),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n));

   always #5 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [15:0] exp_mem [16];
   logic [15:0] obs_mem [16];
   int exp_pulses = 0, pulses = 0, we_falls = 0, oe_bad = 0;
   logic [1:0] last_mask = 2'b00;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] m);
      return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
   endfunction

   task automatic send(input logic [3:0] a, input logic [15:0] d, input logic [1:0] m);
      req_valid = 1; req_addr = AW'(a); req_data = d; req_mask = m;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      exp_mem[a] = merge(exp_mem[a], d, m);
      if (m != 2'b00) exp_pulses++;
      last_mask = m;
   endtask

   task automatic wait_idle();
      while (!(mem_ce_n && req_ready)) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor
   bit mon = 0, have_fall = 0, we_low_run = 0;
   logic p_lb = 1, p_ub = 1, p_we = 1, p_ce = 1, p_dqoe = 0;
   logic [AW-1:0] p_addr = '0;
   logic [15:0] p_data = '0;
   int cyc = 0, run = 0, st_cnt = 0, last_fall = 0, last_rise = 0, we_fall_cyc = 0, we_rise_cyc = 0;

   always @(negedge clk) begin
      cyc++;
      if (mon) begin
         bit any, p_any;
         any = !mem_lb_n || !mem_ub_n;
         p_any = !p_lb || !p_ub;
         if (mem_addr == p_addr && mem_dq_out == p_data) st_cnt++; else st_cnt = 1;
         if (mem_oe_n !== 1'b1) oe_bad++;
         if (any && !p_any) begin
            chk(st_cnt >= T_AS + 1, "R5 setup stability", st_cnt, T_AS + 1);
            chk(!mem_ce_n && !mem_we_n && mem_dq_oe, "R2 strobe qualified", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b001);
            if (have_fall && we_low_run)
               chk((cyc - last_fall) % WORD == 0, "R7 word spacing", cyc - last_fall, WORD);
            have_fall = 1; we_low_run = 1; last_fall = cyc; run = 1;
         end else if (any && p_any) begin
            run++;
            chk(mem_addr == p_addr && mem_dq_out == p_data, "R4 stable in pulse", int'(mem_dq_out), int'(p_data));
         end else if (!any && p_any) begin
            chk(run == T_PW, "R4 pulse width", run, T_PW);
            if (!p_lb) obs_mem[p_addr[3:0]][7:0] = p_data[7:0];
            if (!p_ub) obs_mem[p_addr[3:0]][15:8] = p_data[15:8];
            pulses++; last_rise = cyc;
         end
         if (!mem_we_n && p_we) begin we_falls++; we_fall_cyc = cyc; end
         if (mem_dq_oe && !p_dqoe)
            chk(cyc - we_fall_cyc == T_TURN, "R8 turn-off delay", cyc - we_fall_cyc, T_TURN);
         if (mem_we_n && !p_we) begin
            chk(!mem_dq_oe && p_dqoe, "R9 driver off with write strobe", mem_dq_oe, 0);
            if (last_mask != 2'b00)
               chk(cyc - last_rise == HOLD, "R9 write strobe release", cyc - last_rise, HOLD);
            we_low_run = 0; we_rise_cyc = cyc;
         end
         if (mem_ce_n && !p_ce)
            chk(cyc - we_rise_cyc == 1, "R9 chip select release", cyc - we_rise_cyc, 1);
      end
      p_lb = mem_lb_n; p_ub = mem_ub_n; p_we = mem_we_n; p_ce = mem_ce_n;
      p_dqoe = mem_dq_oe; p_addr = mem_addr; p_data = mem_dq_out;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int wf0;
      void'($urandom(1234));
      for (int i = 0; i < 16; i++) begin exp_mem[i] = '0; obs_mem[i] = '0; end
      repeat (3) @(negedge clk);
      chk(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe && req_ready,
          "R1 reset outputs", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111101);
      rst = 0;
      @(negedge clk);
      chk(mem_ce_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && req_ready,
          "R1 after reset", {mem_ce_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 6'b111101);
      mon = 1;

      // R3 lane mapping and zero mask, directed
      send(4'd3, 16'hA1B2, 2'b01);
      send(4'd3, 16'hC3D4, 2'b10);
      send(4'd3, 16'hFFFF, 2'b00);
      wait_idle();
      chk(obs_mem[3] == 16'hC3B2, "R3 lane mapping", int'(obs_mem[3]), 16'hC3B2);
      chk(pulses == 2, "R3 zero mask no strobe", pulses, 2);

      // R6 R7 back-to-back burst
      wf0 = we_falls;
      for (int i = 0; i < 5; i++) send(4'(i + 5), 16'(16'h1111 * (i + 1)), 2'b11);
      wait_idle();
      chk(we_falls - wf0 == 1, "R6 one write strobe fall per burst", we_falls - wf0, 1);

      // random mix
      for (int i = 0; i < 60; i++) begin
         send(4'($urandom % 16), 16'($urandom), 2'($urandom % 4));
         if ($urandom % 4 == 0) repeat ($urandom % 12) @(negedge clk);
      end
      send(4'd15, 16'h5A5A, 2'b11);
      wait_idle();

      for (int i = 0; i < 16; i++)
         chk(obs_mem[i] == exp_mem[i], "R3 memory contents", int'(obs_mem[i]), int'(exp_mem[i]));
      chk(pulses == exp_pulses, "R3 pulse count", pulses, exp_pulses);
      chk(oe_bad == 0, "R2 output enable held high", oe_bad, 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule